// File: doc/BRIEF.md
# Annealing Search Controller for Interleave Calibration Settings

This block searches a small vector of discrete calibration settings (one small integer per control register) for the combination that gives the lowest measured cost. The cost is never computed inside the block. For each candidate vector, the block asks an external measurement unit for the cost over a request/response handshake, then waits for the answer.

The search is derivative-free. Each proposal changes one randomly chosen control to a value drawn uniformly from that control's legal range. A proposal that does not raise the cost is always taken. A proposal that raises the cost is taken with probability exp(-beta*dE/T). The temperature T starts at a programmable maximum. After every batch of K proposals, T is multiplied by a fractional factor. The search ends when T is no longer above a programmable minimum. On completion the block pulses `done` and holds the best vector found, together with its cost, until the next start.

Software loads the hyperparameters, the limits and a seed, then pulses `start`. The limits and hyperparameters must stay unchanged while `busy` is high.

Top module: `sa_calib_ctrl`

## Requirements
- R1: A `start` pulse while idle loads `init_state` as both the current and the best vector. The first cost request carries exactly `init_state`, and no proposal is made before its cost has returned.
- R2: Every request vector has each control within its [lo, hi] limits, given that `init_state` is within them. A proposal differs from the current vector in at most one control. A control with lo equal to hi never changes.
- R3: A proposal whose cost is lower than or equal to the current cost always becomes the current vector. The next proposal is derived from it.
- R4: The best vector is replaced only when a non-uphill proposal is taken and its cost is strictly below the best cost. `best_cost` always equals the measured cost of `best_state` and never exceeds the cost of `init_state`.
- R5: An uphill proposal (dE > 0) is taken when a 16-bit random value r satisfies r < P[q], where q = floor(4*beta*dE/T). P[0] = 65536, and P[q+1] = floor(P[q]*51039/65536) approximates 65536*exp(-q/4). P is zero for q of 32 or more. With beta = 0 every uphill move is taken. With a beta large enough to make q reach 32, no uphill move is taken.
- R6: Temperatures follow T0 = `t_max` and Tj+1 = floor(Tj*`cool_q`/65536). Exactly `batch_len` proposals are evaluated for each Tj above `t_min`. The total number of cost requests is 1 + `batch_len` times the number of such Tj.
- R7: A cost request stays valid with an unchanged vector until `req_ready` is seen. The controller then waits, for any number of cycles, for `rsp_valid` before continuing.
- R8: Out of reset, `busy`, `done` and `req_valid` are low. At the end of a search, `done` is high for exactly one cycle with `busy` low. `best_state` and `best_cost` then hold until the next accepted start.
- R9: A `start` pulse while `busy` is high has no effect on the running search.
- R10: If `t_max` is not above `t_min`, only the initial vector is measured, and the block finishes with `init_state` as the best vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| init_state | input | NCTRL*SETW | Starting vector, control i in bits [i*SETW +: SETW] |
| lo_lim | input | NCTRL*SETW | Lower limit for each control |
| hi_lim | input | NCTRL*SETW | Upper limit for each control |
| t_max | input | TEMPW | Starting temperature |
| t_min | input | TEMPW | Search stops once T <= t_min |
| cool_q | input | GAMW | Cooling factor, unsigned fraction over 2^GAMW |
| beta | input | BETAW | Acceptance sharpness |
| batch_len | input | KW | Proposals evaluated per temperature |
| seed | input | 32 | Random source seed (zero is replaced by one) |
| req_valid | output | 1 | Cost request valid |
| req_ready | input | 1 | Measurement unit takes the request |
| req_state | output | NCTRL*SETW | Vector to be measured |
| rsp_valid | input | 1 | Measured cost valid |
| rsp_cost | input | COSTW | Measured cost |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_state | output | NCTRL*SETW | Lowest-cost vector found |
| best_cost | output | COSTW | Cost of best_state |

## Verification
The bench drives the search against a cost model in which cost is the weighted distance to a hidden target vector, and it models the controller's state from the requirements. With a very large beta, every uphill step is refused, so the walk is purely greedy. With beta set to zero, every step is taken, so the path follows the candidates and the best vector must still update only on non-uphill moves. A flat cost makes every move an equal-cost move, which separates "lower or equal" acceptance from strict acceptance and shows that the best vector stays at the start vector. A mid-range beta, a pinned control, a start pulse in the middle of a search, and a temperature window that is empty from the outset cover range limits, restart immunity and the degenerate schedule. The request count checks the cooling arithmetic in each case.

// File: rtl/sa_calib_pkg.sv
package sa_calib_pkg;

   localparam int unsigned RND_W         = 16;
   localparam int unsigned EXP_FRAC      = 2;
   localparam int unsigned EXP_RATIO_Q16 = 51039;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_REQ_INIT,
      ST_WAIT_INIT,
      ST_CHECK,
      ST_PROPOSE,
      ST_REQ,
      ST_WAIT,
      ST_JUDGE,
      ST_FIN
   } sa_state_e;

   // probability (scaled by 2^RND_W) of taking an uphill step at quantised index
   function automatic logic [RND_W:0] exp_prob(input int unsigned steps);
      logic [47:0] v;
      v = 48'd65536;
      for (int unsigned i = 0; i < steps; i++) begin
         v = (v * 48'(EXP_RATIO_Q16)) >> 16;
      end
      return v[RND_W:0];
   endfunction

endpackage

// File: rtl/sa_lfsr.sv
module sa_lfsr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   output logic [W-1:0] value
);

   logic [W-1:0] v_q;
   logic         fb;

   generate
      if (W == 32) begin : g_w32
         assign fb = v_q[31] ^ v_q[21] ^ v_q[1] ^ v_q[0];
      end else if (W == 16) begin : g_w16
         assign fb = v_q[15] ^ v_q[14] ^ v_q[12] ^ v_q[3];
      end else begin : g_bad
         $error("sa_lfsr: width must be 16 or 32");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= W'(1);
      end else if (load) begin
         v_q <= (seed == '0) ? W'(1) : seed;
      end else if (step) begin
         v_q <= {v_q[W-2:0], fb};
      end
   end

   assign value = v_q;

endmodule

// File: rtl/sa_neighbor.sv
module sa_neighbor
   import sa_calib_pkg::*;
#(
   parameter int unsigned NCTRL = 6,
   parameter int unsigned SETW  = 8
) (
   input  logic [NCTRL*SETW-1:0] cur,
   input  logic [NCTRL*SETW-1:0] lo,
   input  logic [NCTRL*SETW-1:0] hi,
   input  logic [2*RND_W-1:0]    rnd,
   output logic [NCTRL*SETW-1:0] cand
);

   localparam int unsigned IDXW = $clog2(NCTRL);

   logic [IDXW-1:0]       pick;
   logic [SETW-1:0]       sel_lo;
   logic [SETW-1:0]       sel_hi;
   logic [SETW:0]         span1;
   logic [SETW+RND_W:0]   vprod;
   logic [SETW-1:0]       val;
   logic                  unused_bits;

   // control index: plain slice for a power-of-two count, multiply-shift otherwise
   generate
      if ((NCTRL & (NCTRL - 1)) == 0) begin : g_pick_pow2
         assign pick = rnd[RND_W-1 -: IDXW];
         logic unused_pick;
         assign unused_pick = ^rnd[RND_W-IDXW-1:0];
      end else begin : g_pick_mul
         logic [RND_W+IDXW-1:0] iprod;
         logic unused_pick;
         assign iprod = (RND_W+IDXW)'(NCTRL) * (RND_W+IDXW)'(rnd[RND_W-1:0]);
         assign pick  = iprod[RND_W +: IDXW];
         assign unused_pick = ^iprod[RND_W-1:0];
      end
   endgenerate

   always_comb begin
      sel_lo = '0;
      sel_hi = '0;
      for (int i = 0; i < NCTRL; i++) begin
         if (pick == IDXW'(i)) begin
            sel_lo = lo[i*SETW +: SETW];
            sel_hi = hi[i*SETW +: SETW];
         end
      end
   end

   assign span1 = {1'b0, sel_hi - sel_lo} + (SETW+1)'(1);
   assign vprod = (SETW+RND_W+1)'(span1) * (SETW+RND_W+1)'(rnd[2*RND_W-1:RND_W]);
   assign val   = sel_lo + vprod[RND_W +: SETW];
   assign unused_bits = ^{vprod[RND_W-1:0], vprod[SETW+RND_W]};

   generate
      for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
         assign cand[i*SETW +: SETW] = (pick == IDXW'(i)) ? val : cur[i*SETW +: SETW];
      end
   endgenerate

endmodule

// File: rtl/sa_accept.sv
module sa_accept
   import sa_calib_pkg::*;
#(
   parameter int unsigned COSTW = 16,
   parameter int unsigned BETAW = 8,
   parameter int unsigned TEMPW = 16,
   parameter int unsigned TABN  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [COSTW-1:0] de,
   input  logic [BETAW-1:0] beta,
   input  logic [TEMPW-1:0] temp,
   input  logic [RND_W-1:0] rnd,
   output logic             fin,
   output logic             take
);

   localparam int unsigned NUMW = COSTW + BETAW + EXP_FRAC;
   localparam int unsigned QW   = $clog2(TABN + 1);

   if (NUMW < TEMPW) begin : g_bad_width
      $error("sa_accept: product narrower than temperature");
   end

   logic [NUMW-1:0]  num_q;
   logic [QW-1:0]    q_q;
   logic             run_q;
   logic [RND_W-1:0] rnd_q;
   logic             fin_q;
   logic             take_q;
   logic [RND_W:0]   tab [TABN];
   logic [RND_W:0]   prob;
   logic             stop;

   generate
      for (genvar i = 0; i < TABN; i++) begin : g_tab
         localparam logic [RND_W:0] PV = exp_prob(i);
         assign tab[i] = PV;
      end
   endgenerate

   always_comb begin
      prob = '0;
      for (int i = 0; i < TABN; i++) begin
         if (q_q == QW'(i)) prob = tab[i];
      end
   end

   assign stop = (q_q == QW'(TABN)) || (num_q < NUMW'(temp));

   // serial quotient: counts how many times T fits into 4*beta*dE, up to TABN
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q  <= '0;
         q_q    <= '0;
         run_q  <= 1'b0;
         rnd_q  <= '0;
         fin_q  <= 1'b0;
         take_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            num_q <= (NUMW'(de) * NUMW'(beta)) << EXP_FRAC;
            q_q   <= '0;
            run_q <= 1'b1;
            rnd_q <= rnd;
         end else if (run_q) begin
            if (stop) begin
               run_q  <= 1'b0;
               fin_q  <= 1'b1;
               take_q <= {1'b0, rnd_q} < prob;
            end else begin
               num_q <= num_q - NUMW'(temp);
               q_q   <= q_q + QW'(1);
            end
         end
      end
   end

   assign fin  = fin_q;
   assign take = take_q;

endmodule

// File: rtl/sa_calib_ctrl.sv
module sa_calib_ctrl
   import sa_calib_pkg::*;
#(
   parameter int unsigned NCTRL = 6,
   parameter int unsigned SETW  = 8,
   parameter int unsigned COSTW = 16,
   parameter int unsigned TEMPW = 16,
   parameter int unsigned GAMW  = 16,
   parameter int unsigned BETAW = 8,
   parameter int unsigned KW    = 8,
   parameter int unsigned TABN  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [NCTRL*SETW-1:0] init_state,
   input  logic [NCTRL*SETW-1:0] lo_lim,
   input  logic [NCTRL*SETW-1:0] hi_lim,
   input  logic [TEMPW-1:0]      t_max,
   input  logic [TEMPW-1:0]      t_min,
   input  logic [GAMW-1:0]       cool_q,
   input  logic [BETAW-1:0]      beta,
   input  logic [KW-1:0]         batch_len,
   input  logic [31:0]           seed,
   output logic                  req_valid,
   input  logic                  req_ready,
   output logic [NCTRL*SETW-1:0] req_state,
   input  logic                  rsp_valid,
   input  logic [COSTW-1:0]      rsp_cost,
   output logic                  busy,
   output logic                  done,
   output logic [NCTRL*SETW-1:0] best_state,
   output logic [COSTW-1:0]      best_cost
);

   localparam int unsigned SW = NCTRL * SETW;
   localparam int unsigned LW = 2 * RND_W;

   if (NCTRL < 2) begin : g_bad_nctrl
      $error("sa_calib_ctrl: at least two controls required");
   end
   if (TABN < 1 || TABN > 64) begin : g_bad_tabn
      $error("sa_calib_ctrl: TABN must lie in 1..64");
   end
   if (LW != 32) begin : g_bad_lw
      $error("sa_calib_ctrl: random source must be 32 bits");
   end

   sa_state_e          state_q;
   logic [SW-1:0]      cur_q;
   logic [SW-1:0]      cand_q;
   logic [SW-1:0]      best_q;
   logic [COSTW-1:0]   cur_cost_q;
   logic [COSTW-1:0]   cand_cost_q;
   logic [COSTW-1:0]   best_cost_q;
   logic [TEMPW-1:0]   temp_q;
   logic [KW-1:0]      kcnt_q;

   logic [LW-1:0]          rnd;
   logic [SW-1:0]          nb_cand;
   logic [TEMPW+GAMW-1:0]  cool_prod;
   logic [TEMPW-1:0]       cooled;
   logic                   acc_go;
   logic                   acc_fin;
   logic                   acc_take;
   logic                   uphill;
   logic                   unused_cool;

   assign cool_prod   = (TEMPW+GAMW)'(temp_q) * (TEMPW+GAMW)'(cool_q);
   assign cooled      = cool_prod[GAMW +: TEMPW];
   assign unused_cool = ^cool_prod[GAMW-1:0];

   assign uphill = rsp_cost > cur_cost_q;
   assign acc_go = (state_q == ST_WAIT) && rsp_valid && uphill;

   sa_lfsr #(.W(LW)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ((state_q == ST_IDLE) && start),
      .seed  (seed),
      .step  ((state_q == ST_PROPOSE) || acc_go),
      .value (rnd)
   );

   sa_neighbor #(.NCTRL(NCTRL), .SETW(SETW)) u_nb (
      .cur  (cur_q),
      .lo   (lo_lim),
      .hi   (hi_lim),
      .rnd  (rnd),
      .cand (nb_cand)
   );

   sa_accept #(.COSTW(COSTW), .BETAW(BETAW), .TEMPW(TEMPW), .TABN(TABN)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (acc_go),
      .de    (rsp_cost - cur_cost_q),
      .beta  (beta),
      .temp  (temp_q),
      .rnd   (rnd[RND_W-1:0]),
      .fin   (acc_fin),
      .take  (acc_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_q       <= '0;
         cand_q      <= '0;
         best_q      <= '0;
         cur_cost_q  <= '0;
         cand_cost_q <= '0;
         best_cost_q <= '0;
         temp_q      <= '0;
         kcnt_q      <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  cur_q   <= init_state;
                  best_q  <= init_state;
                  temp_q  <= t_max;
                  kcnt_q  <= '0;
                  state_q <= ST_REQ_INIT;
               end
            end
            ST_REQ_INIT: begin
               if (req_ready) state_q <= ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
               if (rsp_valid) begin
                  cur_cost_q  <= rsp_cost;
                  best_cost_q <= rsp_cost;
                  state_q     <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (temp_q <= t_min) begin
                  state_q <= ST_FIN;
               end else if (kcnt_q == batch_len) begin
                  temp_q <= cooled;
                  kcnt_q <= '0;
               end else begin
                  state_q <= ST_PROPOSE;
               end
            end
            ST_PROPOSE: begin
               cand_q  <= nb_cand;
               state_q <= ST_REQ;
            end
            ST_REQ: begin
               if (req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  cand_cost_q <= rsp_cost;
                  if (!uphill) begin
                     cur_q      <= cand_q;
                     cur_cost_q <= rsp_cost;
                     if (rsp_cost < best_cost_q) begin
                        best_q      <= cand_q;
                        best_cost_q <= rsp_cost;
                     end
                     kcnt_q  <= kcnt_q + KW'(1);
                     state_q <= ST_CHECK;
                  end else begin
                     state_q <= ST_JUDGE;
                  end
               end
            end
            ST_JUDGE: begin
               if (acc_fin) begin
                  if (acc_take) begin
                     cur_q      <= cand_q;
                     cur_cost_q <= cand_cost_q;
                  end
                  kcnt_q  <= kcnt_q + KW'(1);
                  state_q <= ST_CHECK;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid  = (state_q == ST_REQ_INIT) || (state_q == ST_REQ);
   assign req_state  = (state_q == ST_REQ_INIT) ? cur_q : cand_q;
   assign busy       = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign done       = (state_q == ST_FIN);
   assign best_state = best_q;
   assign best_cost  = best_cost_q;

endmodule

// File: rtl/sa_calib_chk.sv
module sa_calib_chk #(
   parameter int unsigned NCTRL = 6,
   parameter int unsigned SETW  = 8,
   parameter int unsigned COSTW = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic [NCTRL*SETW-1:0] lo_lim,
   input logic [NCTRL*SETW-1:0] hi_lim,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [NCTRL*SETW-1:0] req_state,
   input logic                  busy,
   input logic                  done,
   input logic [NCTRL*SETW-1:0] best_state,
   input logic [COSTW-1:0]      best_cost
);

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_state)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !req_valid));

   assert_best_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(best_state) && $stable(best_cost)));

   assert_first_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> req_valid);

   generate
      for (genvar i = 0; i < NCTRL; i++) begin : g_rng
         assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |-> ((req_state[i*SETW +: SETW] >= lo_lim[i*SETW +: SETW]) &&
                           (req_state[i*SETW +: SETW] <= hi_lim[i*SETW +: SETW])));
      end
   endgenerate

endmodule

bind sa_calib_ctrl sa_calib_chk #(.NCTRL(NCTRL), .SETW(SETW), .COSTW(COSTW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .lo_lim     (lo_lim),
   .hi_lim     (hi_lim),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_state  (req_state),
   .busy       (busy),
   .done       (done),
   .best_state (best_state),
   .best_cost  (best_cost)
);

// File: tb/tb_sa_calib_ctrl.sv
`timescale 1ns/1ps
module tb_sa_calib_ctrl;

   localparam int NC = 6;
   localparam int SW = 8;
   localparam int VW = NC * SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [VW-1:0] init_state, lo_lim, hi_lim;
   logic [15:0]   t_max, t_min, cool_q;
   logic [7:0]    beta, batch_len;
   logic [31:0]   seed;
   logic          req_valid, req_ready, rsp_valid;
   logic [VW-1:0] req_state, best_state;
   logic [15:0]   rsp_cost, best_cost;
   logic          busy, done;

   always #10 clk = ~clk;

   sa_calib_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start(start), .init_state(init_state),
      .lo_lim(lo_lim), .hi_lim(hi_lim), .t_max(t_max), .t_min(t_min),
      .cool_q(cool_q), .beta(beta), .batch_len(batch_len), .seed(seed),
      .req_valid(req_valid), .req_ready(req_ready), .req_state(req_state),
      .rsp_valid(rsp_valid), .rsp_cost(rsp_cost), .busy(busy), .done(done),
      .best_state(best_state), .best_cost(best_cost)
   );

   int n_chk = 0;
   int n_err = 0;
   int mode  = 0;   // 0: greedy model, 1: always-take model, 2: no path model
   int cmode = 0;   // 0: distance cost, 1: flat cost
   int cw    = 16;
   int nreq  = 0;
   logic [VW-1:0] mcur, mbest;
   int mcurc, mbestc;

   function automatic logic [VW-1:0] pack(int a, int b, int c, int d, int e, int f);
      return {8'(f), 8'(e), 8'(d), 8'(c), 8'(b), 8'(a)};
   endfunction

   function automatic int fld(logic [VW-1:0] v, int i);
      return int'(v[i*SW +: SW]);
   endfunction

   logic [VW-1:0] tgt;

   function automatic int cost_of(logic [VW-1:0] s);
      int sum = 0;
      if (cmode == 1) return 100;
      for (int i = 0; i < NC; i++) begin
         int d = fld(s, i) - fld(tgt, i);
         sum += (d < 0) ? -d : d;
      end
      return sum * cw;
   endfunction

   function automatic int ndiff(logic [VW-1:0] a, logic [VW-1:0] b);
      int n = 0;
      for (int i = 0; i < NC; i++) if (fld(a, i) != fld(b, i)) n++;
      return n;
   endfunction

   function automatic int batches(int tmx, int tmn, int g);
      longint t = tmx;
      int n = 0;
      while (t > tmn) begin
         n++;
         t = (t * g) >> 16;
      end
      return n;
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic handle(logic [VW-1:0] cap);
      int c;
      bit ok;
      c = cost_of(cap);
      nreq++;
      ok = 1'b1;
      for (int i = 0; i < NC; i++)
         if (fld(cap, i) < fld(lo_lim, i) || fld(cap, i) > fld(hi_lim, i)) ok = 1'b0;
      chk(ok, "R2 request within limits", 0, 0);
      chk(fld(cap, 3) == 40, "R2 pinned control unchanged", fld(cap, 3), 40);
      if (nreq == 1) begin
         chk(cap == init_state, "R1 first request is the start vector", 0, 0);
         mcur = cap; mcurc = c; mbest = cap; mbestc = c;
      end else if (mode != 2) begin
         chk(ndiff(cap, mcur) <= 1, "R2/R3 one-control step from current", ndiff(cap, mcur), 1);
         if (c <= mcurc && c < mbestc) begin
            mbest = cap; mbestc = c;
         end
         if (c <= mcurc || mode == 1) begin
            mcur = cap; mcurc = c;
         end
      end
   endtask

   // measurement unit model with varying latencies
   initial begin
      logic [VW-1:0] cap;
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      rsp_cost  = '0;
      forever begin
         @(negedge clk);
         if (req_valid) begin
            repeat (nreq % 3) @(negedge clk);
            cap = req_state;
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            handle(cap);
            repeat ((nreq + 1) % 4) @(negedge clk);
            rsp_cost  = 16'(cost_of(cap));
            rsp_valid = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
         end
      end
   end

   task automatic run(string name, int md, int cm, int w, int b, int tmx, int tmn,
                      int g, int k, bit restart);
      int exp_req, cyc;
      logic [VW-1:0] bs;
      logic [15:0]   bc;
      mode = md; cmode = cm; cw = w;
      beta = 8'(b); t_max = 16'(tmx); t_min = 16'(tmn); cool_q = 16'(g);
      batch_len = 8'(k);
      nreq = 0;
      exp_req = 1 + k * batches(tmx, tmn, g);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (restart) begin
         wait (nreq >= 5);
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done, {"R8 finish seen (watchdog) ", name}, cyc, 0);
      chk(!busy, {"R8 busy low with done ", name}, busy, 0);
      bs = best_state; bc = best_cost;
      @(negedge clk);
      chk(!done, {"R8 done lasts one cycle ", name}, done, 0);
      chk(nreq == exp_req, {"R6 request count ", name}, nreq, exp_req);
      if (restart) chk(nreq == exp_req, {"R9 start while busy ignored ", name}, nreq, exp_req);
      chk(int'(bc) == cost_of(bs), {"R4 best cost matches best vector ", name}, bc, cost_of(bs));
      chk(int'(bc) <= cost_of(init_state), {"R4 best not worse than start ", name}, bc, cost_of(init_state));
      if (md != 2) begin
         chk(bs == mbest, {"R4 best vector per model ", name}, ndiff(bs, mbest), 0);
         chk(int'(bc) == mbestc, {"R4 best cost per model ", name}, bc, mbestc);
      end
      repeat (4) @(negedge clk);
      chk(best_state == bs && best_cost == bc, {"R8 best held while idle ", name}, best_cost, bc);
   endtask

   initial begin
      #(200000 * 20);
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      tgt        = pack(10, 200, 77, 40, 5, 130);
      lo_lim     = pack(0, 50, 20, 40, 0, 100);
      hi_lim     = pack(255, 250, 90, 40, 31, 160);
      init_state = pack(128, 60, 30, 40, 20, 110);
      seed       = 32'h1234_5678;
      t_max = 16'd64; t_min = 16'd8; cool_q = 16'd52429; beta = 8'd50; batch_len = 8'd30;
      repeat (3) @(negedge clk);
      chk(!busy, "R8 reset busy", busy, 0);
      chk(!done, "R8 reset done", done, 0);
      chk(!req_valid, "R7 reset no request", req_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 greedy: large beta refuses every uphill step (R5), with restart pulse (R9)
      run("greedy", 0, 0, 16, 255, 64, 8, 52429, 30, 1'b1);
      // R5 beta zero: every uphill step taken
      seed = 32'hCAFE_0001;
      run("always", 1, 0, 16, 0, 200, 3, 32768, 10, 1'b0);
      // R3 flat cost: every move is an equal-cost move, best stays at start
      run("flat", 0, 1, 16, 255, 100, 10, 45000, 20, 1'b0);
      // R5 mid-range acceptance with fine cost steps
      seed = 32'h0;
      run("anneal", 2, 0, 1, 50, 64, 8, 52429, 30, 1'b0);
      // R10 empty temperature window
      run("empty", 0, 0, 16, 50, 8, 8, 52429, 30, 1'b0);
      chk(nreq == 1, "R10 only start vector measured", nreq, 1);
      chk(best_state == init_state, "R10 best is start vector", ndiff(best_state, init_state), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule